// File: doc/BRIEF.md
# Daisy-Chainable Serial Switch-Control Register

This block is a three-wire serial slave that sets eight on/off channel enables. A host pulls the active-low frame strobe low, then clocks data in on the serial clock; each falling edge of the serial clock shifts one bit into an eight-bit shift register, most significant bit first. The channel enables stay as they are while the frame is open. They take the new word only when the strobe returns high.

The serial clock, data and strobe are treated as slow inputs sampled by the system clock. Each one passes through a two-flop synchronizer, and edges are found by comparing consecutive synchronized samples. The most significant bit of the shift register is passed to a chain output on serial-clock rising edges. A second device with its data input on that line therefore receives the first byte while the host sends the next byte. The chain output is modelled as an open-drain line: a value plus an enable that pulls the line low. An active-low reset clears the shift register, the channel enables and the chain output.

Top module: `chain_switch_ctl`

## Requirements
- R1: While rst_n is low, chan_en_o and chain_q_o are 0. The shift register is cleared too: a frame with no serial clock edges, opened and closed after reset, leaves chan_en_o at 0.
- R2: Each falling edge of sclk_i seen while frame_n_i is low shifts sdin_i into the shift register, first bit received into bit 7. When the frame closes after eight bits, chan_en_o equals that byte.
- R3: Serial clock edges while frame_n_i is high change neither the shift register nor chain_q_o.
- R4: chan_en_o does not change while a frame is open, even while bits are being shifted in.
- R5: If more than eight bits arrive in one frame, chan_en_o takes only the last eight bits received.
- R6: chain_q_o changes only after a rising edge of sclk_i inside a frame, and then takes bit 7 of the shift register. After eight bits it shows the first bit of the frame, and during the next eight bits it shows the rest of that byte, MSB first.
- R7: chain_drv_o is 1 exactly when chain_q_o is 0; the line is then pulled low, and otherwise it is released.
- R8: A rising edge of frame_n_i, driven between system clock edges, first shows on chan_en_o after the third rising edge of clk. After the second edge chan_en_o still holds the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idle high |
| sdin_i | input | 1 | Serial data input |
| frame_n_i | input | 1 | Active-low frame strobe |
| chan_en_o | output | 8 | Channel enables, one bit per switch |
| chain_q_o | output | 1 | Chain data value for the next device |
| chain_drv_o | output | 1 | Pull-low enable for the open-drain chain line |

## Verification
Single bytes with asymmetric bit patterns (0xA5, 0x3C, 0x01, 0x80) show that the first bit lands in bit 7 and that no bit is lost or repeated at either end. A sixteen-bit frame of two different bytes shows that only the second byte is latched. It also shows, bit by bit, that the chain output delays the first byte by one full byte and moves only on rising edges. Serial clock pulses sent while the strobe is high, followed by an empty frame, show that the shift register did not move. A reset in the middle of a frame, and a strobe edge placed between system clock edges, check the clearing rule and the exact update cycle.

// File: rtl/chain_switch_ctl.sv
module chain_switch_ctl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdin_i,
  input  logic             frame_n_i,
  output logic [WIDTH-1:0] chan_en_o,
  output logic             chain_q_o,
  output logic             chain_drv_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclk_sy, din_sy, frm_sy;
  logic         sclk_d, frm_d;
  logic [WIDTH-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '1;
      din_sy  <= '0;
      frm_sy  <= '1;
      sclk_d  <= 1'b1;
      frm_d   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[TOP-1:0], sclk_i};
      din_sy  <= {din_sy[TOP-1:0], sdin_i};
      frm_sy  <= {frm_sy[TOP-1:0], frame_n_i};
      sclk_d  <= sclk_sy[TOP];
      frm_d   <= frm_sy[TOP];
    end
  end

  wire sclk_s     = sclk_sy[TOP];
  wire din_s      = din_sy[TOP];
  wire frm_s      = frm_sy[TOP];
  wire in_frame   = ~frm_s;
  wire sclk_fall  = sclk_d & ~sclk_s;
  wire sclk_rise  = ~sclk_d & sclk_s;
  wire frame_rise = ~frm_d & frm_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      chain_q_o <= 1'b0;
      chan_en_o <= '0;
    end else begin
      if (in_frame && sclk_fall) shreg <= {shreg[WIDTH-2:0], din_s};
      if (in_frame && sclk_rise) chain_q_o <= shreg[WIDTH-1];
      if (frame_rise) chan_en_o <= shreg;
    end
  end

  assign chain_drv_o = ~chain_q_o;

endmodule

// File: rtl/chain_switch_ctl_chk.sv
module chain_switch_ctl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_s,
  input logic             frame_rise,
  input logic             sclk_rise,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] chan_en_o,
  input logic             chain_q_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (chan_en_o == '0 && chain_q_o == 1'b0));

  assert_latch_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> chan_en_o == $past(shreg));

  assert_idle_no_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_s |=> $stable(shreg));

  assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise |=> $stable(chan_en_o));

  assert_chain_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(chain_q_o));

endmodule

bind chain_switch_ctl chain_switch_ctl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_s(frm_s), .frame_rise(frame_rise),
  .sclk_rise(sclk_rise), .shreg(shreg), .chan_en_o(chan_en_o), .chain_q_o(chain_q_o)
);

// File: tb/chain_switch_ctl_bench.sv
module chain_switch_ctl_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdin = 1'b0, frame_n = 1'b1;
  logic [7:0] chan_en;
  logic chain_q, chain_drv;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chain_switch_ctl u_chain_switch_ctl (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdin_i(sdin), .frame_n_i(frame_n),
    .chan_en_o(chan_en), .chain_q_o(chain_q), .chain_drv_o(chain_drv)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sdin = b; wait_n(H);
    sclk = 1'b0; wait_n(H);
    sclk = 1'b1; wait_n(H);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic frame_byte(input logic [7:0] v);
    frame_n = 1'b0; wait_n(H);
    put_byte(v);
    frame_n = 1'b1; wait_n(8);
  endtask

  task automatic empty_frame();
    frame_n = 1'b0; wait_n(H);
    frame_n = 1'b1; wait_n(8);
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R1 chan_en in reset", chan_en, 8'h00);
    chk("R1 chain_q in reset", {7'b0, chain_q}, 8'h00);
    chk("R7 chain_drv in reset", {7'b0, chain_drv}, 8'h01);
    rst_n = 1'b1; wait_n(4);
    empty_frame();
    chk("R1 empty frame after reset", chan_en, 8'h00);
  endtask

  task automatic t_basic(input logic [7:0] v);
    frame_byte(v);
    chk("R2 latched byte", chan_en, v);
  endtask

  task automatic t_hold();
    frame_n = 1'b0; wait_n(H);
    put_byte(8'h5A);
    chk("R4 hold while frame open", chan_en, 8'h80);
    frame_n = 1'b1; wait_n(8);
    chk("R2 new byte after close", chan_en, 8'h5A);
  endtask

  task automatic t_chain(input logic [7:0] a, input logic [7:0] b);
    logic prev;
    frame_n = 1'b0; wait_n(H);
    put_byte(a);
    chk("R6 first bit on chain", {7'b0, chain_q}, {7'b0, a[7]});
    chk("R7 drive vs value", {7'b0, chain_drv}, {7'b0, ~a[7]});
    prev = a[7];
    for (int j = 1; j <= 8; j++) begin
      logic e;
      e = (j == 8) ? b[7] : a[7-j];
      sdin = b[8-j]; wait_n(H);
      sclk = 1'b0; wait_n(H);
      chk("R6 stable after fall", {7'b0, chain_q}, {7'b0, prev});
      sclk = 1'b1; wait_n(H);
      chk("R6 chain bit after rise", {7'b0, chain_q}, {7'b0, e});
      chk("R7 drive vs value", {7'b0, chain_drv}, {7'b0, ~e});
      prev = e;
    end
    chk("R4 hold during long frame", chan_en, 8'h5A);
    frame_n = 1'b1; wait_n(8);
    chk("R5 last eight bits latched", chan_en, b);
  endtask

  task automatic t_ignore();
    logic q0;
    q0 = chain_q;
    for (int i = 0; i < 8; i++) put_bit(i[0]);
    chk("R3 chain_q unchanged", {7'b0, chain_q}, {7'b0, q0});
    empty_frame();
    chk("R3 shift register unchanged", chan_en, 8'hC3);
  endtask

  task automatic t_latency();
    frame_n = 1'b0; wait_n(H);
    put_byte(8'h96);
    frame_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 old after two edges", chan_en, 8'hC3);
    @(posedge clk); @(negedge clk);
    chk("R8 new after third edge", chan_en, 8'h96);
    wait_n(4);
  endtask

  task automatic t_reset_mid();
    frame_n = 1'b0; wait_n(H);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    rst_n = 1'b0; wait_n(3);
    chk("R1 chan_en cleared mid frame", chan_en, 8'h00);
    chk("R1 chain_q cleared mid frame", {7'b0, chain_q}, 8'h00);
    frame_n = 1'b1; wait_n(2);
    rst_n = 1'b1; wait_n(4);
    empty_frame();
    chk("R1 shift register cleared", chan_en, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic(8'hA5);
    t_basic(8'h3C);
    t_basic(8'h01);
    t_basic(8'h80);
    t_hold();
    t_chain(8'hB2, 8'hC3);
    t_ignore();
    t_latency();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule